// File: doc/BRIEF.md
# Two-Channel Static-Run Output Muter

This block sits in the sample path ahead of a stereo DAC. Each time the frame strobe marks a new pair of signed sample words, it checks whether each word is static: every bit clear (zero) or every bit set (minus one). Each channel counts how many static samples in a row it has seen. A run counts only while it keeps the same constant value.

When a channel's run reaches the configured length (8192 samples by default), that channel enters mute. Its mute flag rises, and its output word is forced to signed zero, which is the mid-scale level of the converter. The first non-static sample clears the mute on the same update and is passed straight through. The two channels are detected and muted independently.

The block registers its outputs. Each valid strobe updates the output words and the mute flags one clock later. Cycles without the strobe leave every output and every run count unchanged.

Top module: `auto_mute_det`

## Requirements
- R1: A synchronous reset (active high) clears both run counts, drives both output words to zero and drives both mute flags low.
- R2: A channel's mute flag stays low after RUN_LEN-1 consecutive all-zero valid samples and goes high on the update that follows the RUN_LEN-th one.
- R3: A run of all-ones (value -1) samples mutes a channel in the same way, and while a channel is muted its output word is all zeros even though the input is all ones.
- R4: A valid sample that is neither all zeros nor all ones clears that channel's mute flag on the update that follows it, and the same update passes the sample to the output.
- R5: A change from an all-zero run to an all-ones run, or the reverse, restarts the count at one, so the channel mutes only after RUN_LEN samples of the new value.
- R6: The left and right channels count and mute independently; static data on one channel never mutes the other.
- R7: Clock cycles with the valid strobe low change no output and do not advance, break or clear any run, whatever data is on the inputs.
- R8: The run count saturates at RUN_LEN: a channel that keeps receiving static samples long past RUN_LEN stays muted.
- R9: While a channel is not muted, each valid sample appears unchanged on that channel's output one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | High for one cycle per frame when both sample words are valid |
| left_in | input | W | Left signed sample word |
| right_in | input | W | Right signed sample word |
| left_out | output | W | Left sample after muting, registered |
| right_out | output | W | Right sample after muting, registered |
| mute_l | output | 1 | Left mute flag, high while left is muted |
| mute_r | output | 1 | Right mute flag, high while right is muted |

## Verification
A run count that is off by even one moves the mute edge by one sample. The bench therefore samples the flag on both sides of the RUN_LEN boundary, and the error shows up within a single frame. A run count that wraps or misses a value change shows up either as a mute that drops during a long static run or as a mute that arrives too early after a switch from zero to minus one. A stale mute state shows up on the very first non-static sample, as a held flag or a zeroed word. Gaps without the valid strobe carry non-static data, so a design that samples without the strobe is caught at once.

// File: rtl/auto_mute_det.sv
module auto_mute_det #(
  parameter int W       = 24,
  parameter int RUN_LEN = 8192
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  output logic [W-1:0] left_out,
  output logic [W-1:0] right_out,
  output logic         mute_l,
  output logic         mute_r
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);

  logic [W-1:0] din [2];
  assign din[0] = left_in;
  assign din[1] = right_in;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CW-1:0] cnt, cnt_nx;
    logic          run_ones;
    logic          mq;
    logic [W-1:0]  oq;
    logic          is_zero, is_ones, is_static, same_run, mute_nx;

    assign is_zero   = (din[c] == '0);
    assign is_ones   = &din[c];
    assign is_static = is_zero | is_ones;
    assign same_run  = (cnt != '0) && (run_ones == is_ones);

    always_comb begin
      if (!is_static)          cnt_nx = '0;
      else if (!same_run)      cnt_nx = CW'(1);
      else if (cnt == CNT_MAX) cnt_nx = cnt;
      else                     cnt_nx = cnt + CW'(1);
    end

    assign mute_nx = (cnt_nx == CNT_MAX);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt      <= '0;
        run_ones <= 1'b0;
        mq       <= 1'b0;
        oq       <= '0;
      end else if (smp_vld) begin
        cnt      <= cnt_nx;
        run_ones <= is_ones;
        mq       <= mute_nx;
        oq       <= mute_nx ? '0 : din[c];
      end
    end
  end

  assign left_out  = g_ch[0].oq;
  assign right_out = g_ch[1].oq;
  assign mute_l    = g_ch[0].mq;
  assign mute_r    = g_ch[1].mq;
endmodule

module auto_mute_det_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_vld,
  input logic [W-1:0] left_in,
  input logic [W-1:0] right_in,
  input logic [W-1:0] left_out,
  input logic [W-1:0] right_out,
  input logic         mute_l,
  input logic         mute_r
);
  function automatic logic stat(input logic [W-1:0] x);
    return (x == '0) || (&x);
  endfunction

  p_muted_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mute_l |-> left_out == '0) and (mute_r |-> right_out == '0));

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !stat(left_in)) |=> (!mute_l && left_out == $past(left_in)));

  p_release_right_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !stat(right_in)) |=> (!mute_r && right_out == $past(right_in)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(left_out) && $stable(right_out) && $stable(mute_l) && $stable(mute_r)));

  p_mute_on_static_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !mute_l && !stat(left_in)) |=> !$rose(mute_l));
endmodule

bind auto_mute_det auto_mute_det_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .left_in(left_in), .right_in(right_in),
  .left_out(left_out), .right_out(right_out), .mute_l(mute_l), .mute_r(mute_r)
);

// File: tb/auto_mute_det_tb.sv
module auto_mute_det_tb_top;
  localparam int W = 24;
  localparam int RL = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [W-1:0] left_in = '0, right_in = '0;
  logic [W-1:0] left_out, right_out;
  logic mute_l, mute_r;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  auto_mute_det #(.W(W), .RUN_LEN(RL)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .mute_l(mute_l), .mute_r(mute_r)
  );

  typedef struct packed {
    logic v;
    logic [W-1:0] l, r, el, er;
    logic eml, emr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{1'b1, 24'h000123, 24'hFFF000, 24'h000123, 24'hFFF000, 1'b0, 1'b0},
    '{1'b1, 24'h000000, 24'h7FFFFF, 24'h000000, 24'h7FFFFF, 1'b0, 1'b0},
    '{1'b0, 24'h111111, 24'h222222, 24'h000000, 24'h7FFFFF, 1'b0, 1'b0},
    '{1'b1, 24'hFFFFFF, 24'h800000, 24'hFFFFFF, 24'h800000, 1'b0, 1'b0},
    '{1'b1, 24'h800000, 24'h000001, 24'h800000, 24'h000001, 1'b0, 1'b0},
    '{1'b1, 24'h000000, 24'hFFFFFF, 24'h000000, 24'hFFFFFF, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_vld = v; left_in = l; right_in = r;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic run(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      smp_vld = 1'b1; left_in = l; right_in = r;
      @(negedge clk);
    end
    smp_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 left_out", left_out, '0);
    chk("R1 right_out", right_out, '0);
    chk("R1 mute_l", W'(mute_l), '0);
    chk("R1 mute_r", W'(mute_r), '0);

    for (int k = 0; k < NV; k++) begin
      step(VT[k].v, VT[k].l, VT[k].r);
      chk("R9/R7 table left", left_out, VT[k].el);
      chk("R9/R7 table right", right_out, VT[k].er);
      chk("R9 table mute_l", W'(mute_l), W'(VT[k].eml));
      chk("R9 table mute_r", W'(mute_r), W'(VT[k].emr));
    end

    do_reset();
    run(RL - 1, 24'h000000, 24'h000555);
    chk("R2 no mute at RUN_LEN-1", W'(mute_l), '0);
    step(1'b1, 24'h000000, 24'h000555);
    chk("R2 mute at RUN_LEN", W'(mute_l), 24'd1);
    chk("R6 right unaffected", W'(mute_r), '0);
    chk("R6 right passes", right_out, 24'h000555);
    step(1'b1, 24'h000123, 24'h000555);
    chk("R4 release flag", W'(mute_l), '0);
    chk("R4 release data", left_out, 24'h000123);

    do_reset();
    run(4000, 24'h000000, 24'h000000);
    run(RL - 1, 24'hFFFFFF, 24'hFFFFFF);
    chk("R5 restart no mute", W'(mute_l), '0);
    chk("R5 restart right", W'(mute_r), '0);
    chk("R5 restart passes -1", left_out, 24'hFFFFFF);
    step(1'b1, 24'hFFFFFF, 24'hFFFFFF);
    chk("R3 ones mute_l", W'(mute_l), 24'd1);
    chk("R3 ones mute_r", W'(mute_r), 24'd1);
    chk("R3 muted left zero", left_out, '0);
    chk("R3 muted right zero", right_out, '0);

    do_reset();
    run(RL - 1, 24'h000000, 24'h000000);
    for (int g = 0; g < 10; g++) step(1'b0, 24'h0ABCDE, 24'h0ABCDE);
    chk("R7 idle no mute", W'(mute_l), '0);
    chk("R7 idle holds output", left_out, '0);
    step(1'b1, 24'h000000, 24'h000000);
    chk("R7 run survives gap", W'(mute_l), 24'd1);
    run(9000, 24'h000000, 24'h000000);
    chk("R8 saturate left", W'(mute_l), 24'd1);
    chk("R8 saturate right", W'(mute_r), 24'd1);
    step(1'b1, 24'h000000, 24'h400000);
    chk("R6 left stays muted", W'(mute_l), 24'd1);
    chk("R4 right released", W'(mute_r), '0);
    chk("R4 right data", right_out, 24'h400000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule